// File: doc/BRIEF.md
# Segment Descriptor Access-Rights Checker

This block performs the check-and-load step of a load-access-rights operation in a protected-mode segmented processor. A request carries a selector operand and the current privilege level (CPL). The block decodes the selector and checks it against the limit of the global or local descriptor table. If that check passes, it fetches the high doubleword of the descriptor over a request/response memory port. It then decides whether the access rights may be returned. The result is a one-cycle done pulse that carries a success flag (ZF), an invalid-opcode flag, and the masked access-rights word.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a caller that raises `req_valid` while the block is busy is stalled until the current check finishes.

The memory request side is also valid/ready. Once `mem_req_valid` is raised, it and the address stay stable until `mem_req_ready` accepts them. The memory answers with a `mem_rsp_valid` pulse and has no back-pressure. The result port has no back-pressure either: `res_valid` is high for exactly one cycle. The mode inputs and the lock-prefix input are plain levels, sampled when a request is taken.

Top module: `seg_rights_checker`

## Requirements
- R1: Only bits 15:0 of `req_selector` are used. The higher bits have no effect on the result or on the memory address.
- R2: The selector is decoded as index in bits 15:3, table select in bit 2 (0 = global table, 1 = local table) and RPL in bits 1:0. The fetch goes to the table picked by bit 2 (`mem_req_ldt`) at byte offset index×8+4.
- R3: If index×8 is greater than the limit of the selected table, the result has ZF=0 and no memory request is issued.
- R4: A selector with index 0 and table bit 0 gives ZF=0 and no memory request.
- R5: The descriptor fields are: S in bit 12, type in bits 11:8, and DPL in bits 14:13. If the segment is not conforming code and either CPL>DPL or RPL>DPL, ZF=0. A segment is conforming code when S=1 and type bits 3 and 2 are both 1; it skips the privilege comparison.
- R6: With `mode_long`=0, system descriptors (S=0) of types 1, 2, 3, 4, 5, 9, B and C are valid. All other system types give ZF=0.
- R7: With `mode_long`=1, only system types 2, 9, B and C are valid. Code/data descriptors (S=1) are valid in both modes.
- R8: On success, ZF=1 and `res_rights` equals the fetched doubleword ANDed with 0x00FFFF00.
- R9: When `mode_real`, `mode_v86` or `lock_prefix` is high at request time, the result has `res_ud`=1 and ZF=0, and no memory request is issued.
- R10: `req_ready` is high only in idle. `mem_req_valid` and `mem_req_offset` hold steady until accepted. `res_valid` lasts exactly one cycle per request.
- R11: When ZF=0, `res_rights` keeps the value of the last successful result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_selector | input | SEL_IN_W | Selector operand (bits 15:0 used) |
| req_cpl | input | 2 | Current privilege level |
| mode_long | input | 1 | 64-bit mode type table in force |
| mode_real | input | 1 | Real-address mode |
| mode_v86 | input | 1 | Virtual-8086 mode |
| lock_prefix | input | 1 | LOCK prefix present |
| gdt_limit | input | LIMIT_W | Global descriptor table limit |
| ldt_limit | input | LIMIT_W | Local descriptor table limit |
| mem_req_valid | output | 1 | Descriptor fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_ldt | output | 1 | Fetch from the local table |
| mem_req_offset | output | LIMIT_W | Byte offset of the high doubleword |
| mem_rsp_valid | input | 1 | Fetched data valid |
| mem_rsp_data | input | 32 | Descriptor high doubleword |
| res_valid | output | 1 | One-cycle done pulse |
| res_zf | output | 1 | Access rights loaded |
| res_ud | output | 1 | Invalid-opcode indication |
| res_rights | output | 32 | Masked access-rights word |

## Verification
The hardest case to reach is the boundary between the limit check and the fetch. It needs a selector whose offset equals the last legal entry, another one entry past it, and in each case proof that no memory transaction happened. The bench memory model counts every accepted fetch and records its table and offset. Stimulus steps the index across both table limits, and every failing path is confirmed against that count. The memory model also withholds ready and delays the response, which holds the block in its fetch and wait states while a second request is presented.

// File: rtl/seg_rights_pkg.sv
package seg_rights_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_DECIDE
  } chk_state_e;

  localparam logic [31:0] RIGHTS_KEEP   = 32'h00FF_FF00;
  // one bit per system type, set when that type is accepted
  localparam logic [15:0] SYS_OK_LEGACY = 16'h1A3E;
  localparam logic [15:0] SYS_OK_WIDE   = 16'h1A04;

  function automatic logic sys_type_ok(input logic [3:0] t, input logic wide);
    logic [15:0] tbl;
    tbl = wide ? SYS_OK_WIDE : SYS_OK_LEGACY;
    return tbl[t];
  endfunction

endpackage

// File: rtl/sel_decode.sv
module sel_decode #(
  parameter int LIMIT_W = 32
) (
  input  logic [15:0]        sel,
  input  logic [LIMIT_W-1:0] gdt_limit,
  input  logic [LIMIT_W-1:0] ldt_limit,
  output logic [LIMIT_W-1:0] entry_off,
  output logic               use_ldt,
  output logic [1:0]         rpl,
  output logic               is_null,
  output logic               over_limit
);
  localparam int PAD_W = LIMIT_W - 16;

  logic [LIMIT_W-1:0] lim;

  always_comb begin
    entry_off  = {{PAD_W{1'b0}}, sel[15:3], 3'b000};
    use_ldt    = sel[2];
    rpl        = sel[1:0];
    is_null    = (sel[15:3] == 13'd0) && !sel[2];
    lim        = sel[2] ? ldt_limit : gdt_limit;
    over_limit = entry_off > lim;
  end
endmodule

// File: rtl/rights_judge.sv
module rights_judge
  import seg_rights_pkg::*;
(
  input  logic [31:0] hi_word,
  input  logic [1:0]  cpl,
  input  logic [1:0]  rpl,
  input  logic        wide_mode,
  output logic        grant,
  output logic [31:0] rights
);
  logic       s_bit;
  logic [3:0] kind;
  logic [1:0] dpl;
  logic       conforming;
  logic       priv_ok;
  logic       type_ok;

  always_comb begin
    s_bit      = hi_word[12];
    kind       = hi_word[11:8];
    dpl        = hi_word[14:13];
    conforming = s_bit && kind[3] && kind[2];
    priv_ok    = conforming || ((cpl <= dpl) && (rpl <= dpl));
    type_ok    = s_bit || sys_type_ok(kind, wide_mode);
    grant      = priv_ok && type_ok;
    rights     = hi_word & RIGHTS_KEEP;
  end
endmodule

// File: rtl/seg_rights_checker.sv
module seg_rights_checker
  import seg_rights_pkg::*;
#(
  parameter int SEL_IN_W = 32,
  parameter int LIMIT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [SEL_IN_W-1:0] req_selector,
  input  logic [1:0]          req_cpl,
  input  logic                mode_long,
  input  logic                mode_real,
  input  logic                mode_v86,
  input  logic                lock_prefix,
  input  logic [LIMIT_W-1:0]  gdt_limit,
  input  logic [LIMIT_W-1:0]  ldt_limit,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_ldt,
  output logic [LIMIT_W-1:0]  mem_req_offset,
  input  logic                mem_rsp_valid,
  input  logic [31:0]         mem_rsp_data,
  output logic                res_valid,
  output logic                res_zf,
  output logic                res_ud,
  output logic [31:0]         res_rights
);
  localparam logic [LIMIT_W-1:0] HI_DW_OFF = LIMIT_W'(4);

  chk_state_e         state;
  logic [LIMIT_W-1:0] off_q;
  logic               ldt_q;
  logic [1:0]         rpl_q;
  logic [1:0]         cpl_q;
  logic               wide_q;
  logic               early_fail_q;
  logic               ud_q;
  logic [31:0]        hi_q;

  logic               sel_unused;
  logic [LIMIT_W-1:0] dec_off;
  logic               dec_ldt;
  logic [1:0]         dec_rpl;
  logic               dec_null;
  logic               dec_over;
  logic               ud_now;
  logic               grant;
  logic [31:0]        rights_m;
  logic               take;

  assign sel_unused = ^req_selector[SEL_IN_W-1:16];

  sel_decode #(.LIMIT_W(LIMIT_W)) u_dec (
    .sel        (req_selector[15:0]),
    .gdt_limit  (gdt_limit),
    .ldt_limit  (ldt_limit),
    .entry_off  (dec_off),
    .use_ldt    (dec_ldt),
    .rpl        (dec_rpl),
    .is_null    (dec_null),
    .over_limit (dec_over)
  );

  rights_judge u_judge (
    .hi_word   (hi_q),
    .cpl       (cpl_q),
    .rpl       (rpl_q),
    .wide_mode (wide_q),
    .grant     (grant),
    .rights    (rights_m)
  );

  assign req_ready      = (state == ST_IDLE);
  assign take           = req_valid && req_ready;
  assign ud_now         = mode_real || mode_v86 || lock_prefix;
  assign mem_req_valid  = (state == ST_FETCH);
  assign mem_req_ldt    = ldt_q;
  assign mem_req_offset = off_q + HI_DW_OFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      off_q        <= '0;
      ldt_q        <= 1'b0;
      rpl_q        <= 2'd0;
      cpl_q        <= 2'd0;
      wide_q       <= 1'b0;
      early_fail_q <= 1'b0;
      ud_q         <= 1'b0;
      hi_q         <= '0;
      res_valid    <= 1'b0;
      res_zf       <= 1'b0;
      res_ud       <= 1'b0;
      res_rights   <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            off_q        <= dec_off;
            ldt_q        <= dec_ldt;
            rpl_q        <= dec_rpl;
            cpl_q        <= req_cpl;
            wide_q       <= mode_long;
            ud_q         <= ud_now;
            early_fail_q <= ud_now || dec_null || dec_over;
            state        <= (ud_now || dec_null || dec_over) ? ST_DECIDE : ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            hi_q  <= mem_rsp_data;
            state <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          res_valid <= 1'b1;
          res_ud    <= ud_q;
          res_zf    <= !early_fail_q && grant;
          if (!early_fail_q && grant) res_rights <= rights_m;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_rights_checker_sva.sv
module seg_rights_checker_sva #(
  parameter int LIMIT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [LIMIT_W-1:0] mem_req_offset,
  input logic               res_valid,
  input logic               res_zf,
  input logic               res_ud,
  input logic [31:0]        res_rights
);
  // R10: a fetch held back by the memory keeps its request and address
  a_r10_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_offset));

  // R10: no new request taken while a fetch is outstanding
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R8: returned word carries no base or limit bits
  a_r8_rights_masked: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_zf |-> (res_rights & 32'hFF00_00FF) == 32'd0);

  // R9: an invalid-opcode result never reports success
  a_r9_ud_no_zf: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ud |-> !res_zf);

  // R11: a failed check leaves the destination word as it was
  a_r11_rights_kept: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_zf |-> $stable(res_rights));
endmodule

bind seg_rights_checker seg_rights_checker_sva #(.LIMIT_W(LIMIT_W)) u_sva (.*);

// File: tb/seg_rights_checker_bench.sv
module seg_rights_checker_bench;
  localparam int LW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_selector = '0;
  logic [1:0]  req_cpl = '0;
  logic        mode_long = 1'b0, mode_real = 1'b0, mode_v86 = 1'b0, lock_prefix = 1'b0;
  logic [LW-1:0] gdt_limit = 32'h7F;
  logic [LW-1:0] ldt_limit = 32'h3F;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_ldt;
  logic [LW-1:0] mem_req_offset;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid, res_zf, res_ud;
  logic [31:0] res_rights;

  always #2.5 clk = ~clk;

  seg_rights_checker u_seg_rights_checker (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [31:0] gdt_hi [32];
  logic [31:0] ldt_hi [32];
  logic [33:0] exp_q [$];
  string       tag_q [$];
  int  res_count = 0, fetch_count = 0;
  int  mem_stall = 0, mem_lat = 0;
  logic [LW-1:0] last_off = '0;
  logic last_ldt = 0;
  logic [31:0] model_rights = '0;
  logic prev_valid = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit s, input logic [3:0] t, input logic [1:0] dpl);
    return {8'hA5, 4'hC, 4'h9, 1'b1, dpl, s, t, 8'h3C};
  endfunction

  function automatic bit legacy_ok(input logic [3:0] t);
    case (t)
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h9, 4'hB, 4'hC: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit wide_ok(input logic [3:0] t);
    case (t)
      4'h2, 4'h9, 4'hB, 4'hC: return 1;
      default: return 0;
    endcase
  endfunction

  // memory model: optional ready stall, then optional response latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (mem_stall) begin
          check(!req_ready, "R10", "ready while fetching", req_ready, 0);
          @(negedge clk);
        end
        mem_req_ready = 1'b1;
        last_off = mem_req_offset;
        last_ldt = mem_req_ldt;
        @(negedge clk);
        mem_req_ready = 1'b0;
        fetch_count++;
        repeat (mem_lat) @(negedge clk);
        mem_rsp_data  = last_ldt ? ldt_hi[last_off[7:3]] : gdt_hi[last_off[7:3]];
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid && prev_valid) check(0, "R10", "done wider than one cycle", 1, 0);
      if (res_valid) begin
        if (exp_q.size() == 0) check(0, "R10", "unexpected result", 1, 0);
        else begin
          logic [33:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(res_zf == e[33], t, "zf", res_zf, e[33]);
          check(res_ud == e[32], t, "ud", res_ud, e[32]);
          check(res_rights == e[31:0], t, "rights", res_rights, e[31:0]);
        end
        res_count++;
      end
      prev_valid <= res_valid;
    end
  end

  task automatic run(input string tag, input logic [31:0] sel, input logic [1:0] cpl,
                     input bit lng, input bit rl, input bit v86, input bit lk);
    logic [15:0] s;
    logic [12:0] idx;
    bit ud, nul, over, fetch, zf, conf;
    logic [31:0] hi;
    logic [LW-1:0] off;
    int f0, r0;
    s    = sel[15:0];
    idx  = s[15:3];
    ud   = rl || v86 || lk;
    nul  = (idx == 0) && !s[2];
    off  = LW'({idx, 3'b000});
    over = off > (s[2] ? ldt_limit : gdt_limit);
    fetch = !ud && !nul && !over;
    zf = 0;
    if (fetch) begin
      hi = s[2] ? ldt_hi[idx[4:0]] : gdt_hi[idx[4:0]];
      conf = hi[12] && hi[11] && hi[10];
      zf = (conf || (cpl <= hi[14:13] && s[1:0] <= hi[14:13])) &&
           (hi[12] || (lng ? wide_ok(hi[11:8]) : legacy_ok(hi[11:8])));
      if (zf) model_rights = hi & 32'h00FFFF00;
    end
    exp_q.push_back({zf, ud, model_rights});
    tag_q.push_back(tag);
    f0 = fetch_count;
    r0 = res_count;
    @(negedge clk);
    req_valid = 1; req_selector = sel; req_cpl = cpl;
    mode_long = lng; mode_real = rl; mode_v86 = v86; lock_prefix = lk;
    @(negedge clk);
    req_valid = 0; req_selector = 32'hFFFF_FFFF;
    mode_real = 0; mode_v86 = 0; lock_prefix = 0;
    while (res_count == r0) @(negedge clk);
    check(fetch_count - f0 == (fetch ? 1 : 0), tag, "fetch count", fetch_count - f0, fetch ? 1 : 0);
    if (fetch) begin
      check(last_off == off + 4, "R2", "fetch offset", last_off, off + 4);
      check(last_ldt == s[2], "R2", "fetch table", last_ldt, s[2]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      gdt_hi[i] = mk(1, 4'h2, 2'd3);
      ldt_hi[i] = mk(1, 4'h3, 2'd3);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1, "R10", "ready after reset", req_ready, 1);
    check(res_valid == 0, "R10", "no result after reset", res_valid, 0);
    check(mem_req_valid == 0, "R10", "no fetch after reset", mem_req_valid, 0);

    gdt_hi[1] = mk(1, 4'h3, 2'd3);
    run("R8", 32'h0000_0008, 2'd0, 0, 0, 0, 0);
    gdt_hi[1] = mk(1, 4'hA, 2'd2);
    run("R1", 32'hDEAD_0009, 2'd1, 0, 0, 0, 0);
    ldt_hi[2] = mk(1, 4'h2, 2'd1);
    run("R2", 32'h0000_0014, 2'd1, 0, 0, 0, 0);
    run("R4", 32'h0000_0003, 2'd0, 0, 0, 0, 0);
    run("R11", 32'h0000_0000, 2'd0, 0, 0, 0, 0);
    gdt_hi[15] = mk(1, 4'h0, 2'd3);
    run("R3", 32'h0000_0078, 2'd0, 0, 0, 0, 0);
    run("R3", 32'h0000_0080, 2'd0, 0, 0, 0, 0);
    run("R3", 32'h0000_0044, 2'd0, 0, 0, 0, 0);
    ldt_hi[7] = mk(1, 4'h1, 2'd0);
    run("R3", 32'h0000_003C, 2'd0, 0, 0, 0, 0);

    gdt_hi[3] = mk(1, 4'hA, 2'd1);
    run("R5", 32'h0000_0018, 2'd2, 0, 0, 0, 0);
    gdt_hi[3] = mk(1, 4'hA, 2'd2);
    run("R5", 32'h0000_001B, 2'd0, 0, 0, 0, 0);
    gdt_hi[4] = mk(1, 4'hE, 2'd0);
    run("R5", 32'h0000_0023, 2'd3, 0, 0, 0, 0);
    gdt_hi[4] = mk(1, 4'h6, 2'd0);
    run("R5", 32'h0000_0020, 2'd1, 0, 0, 0, 0);

    for (int t = 0; t < 16; t++) begin
      gdt_hi[5] = mk(0, 4'(t), 2'd3);
      run("R6", 32'h0000_0028, 2'd0, 0, 0, 0, 0);
    end
    for (int t = 0; t < 16; t++) begin
      gdt_hi[6] = mk(0, 4'(t), 2'd3);
      run("R7", 32'h0000_0030, 2'd0, 1, 0, 0, 0);
    end
    gdt_hi[6] = mk(1, 4'h0, 2'd3);
    run("R7", 32'h0000_0030, 2'd0, 1, 0, 0, 0);

    run("R9", 32'h0000_0008, 2'd0, 0, 1, 0, 0);
    run("R9", 32'h0000_0008, 2'd0, 0, 0, 1, 0);
    run("R9", 32'h0000_0008, 2'd0, 1, 0, 0, 1);

    mem_stall = 3;
    mem_lat = 4;
    gdt_hi[9] = mk(1, 4'h7, 2'd3);
    run("R10", 32'h0000_004B, 2'd3, 0, 0, 0, 0);
    mem_stall = 1;
    mem_lat = 0;
    ldt_hi[5] = mk(0, 4'hC, 2'd3);
    run("R10", 32'h0000_002E, 2'd2, 1, 0, 0, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10", "results outstanding", exp_q.size(), 0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule